// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block turns single commands from a simple valid/ready port into strobe and acknowledge exchanges on a PHY's internal control-register bus. It drives a 16-bit data bus toward the PHY and four strobes: capture-address, capture-data, write and read. It watches the PHY's acknowledge line and its 16-bit return bus. Each strobe is a full four-phase exchange. The block raises the strobe and waits for acknowledge high, then lowers the strobe and waits for acknowledge low.

A command is an address load, a data write or a data read. The block accepts one command at a time. When the command ends it gives a one-cycle done pulse, an error flag and, for reads, the captured word. Every wait for an acknowledge edge is bounded by a cycle limit. A write whose data carries the PHY reset bit raises the write strobe without waiting for acknowledge, because a PHY held in reset cannot answer.

Top module: `phy_cr_master`

## Requirements
- R1: While reset is asserted, and right after it, cmd_ready_o is 1, all four strobes are 0, done_o is 0 and cr_din_o is 0.
- R2: An address load (cmd_op_i = 0) drives cmd_data_i onto cr_din_o and runs one capture-address exchange. It then gives a done pulse with err_o = 0. done_o is never high for two cycles in a row.
- R3: A data write (cmd_op_i = 1) with bit 0 of the data clear drives the data onto cr_din_o and runs a capture-data exchange and then a write exchange. Only after that does it report done with err_o = 0, so the value is committed in the PHY.
- R4: A data read (cmd_op_i = 2) runs a read exchange. rdata_o returns the cr_dout_i word sampled while acknowledge was high, with err_o = 0.
- R5: A data write with bit 0 of the data set (the PHY reset bit) runs the capture-data exchange and then raises cr_write_o without waiting for acknowledge. done_o is high, with err_o = 0, in the same cycle cr_write_o is high. cr_write_o is low again in the next cycle.
- R6: If acknowledge does not rise within LIMIT cycles of a strobe going high, the strobe stays high for exactly LIMIT cycles and the command ends with err_o = 1.
- R7: If acknowledge does not fall within LIMIT cycles of a strobe going low, the command ends with err_o = 1.
- R8: When err_o is high, all strobes are low. A later command runs normally.
- R9: At most one strobe is high at any time. cmd_ready_o is high only when no command is in flight, and it drops in the cycle after a command is accepted.
- R10: The reserved code cmd_op_i = 3 raises no strobe and reports done with err_o = 1 one cycle after it is accepted.
- R11: cr_din_o does not change while any strobe stays high. A read does not change cr_din_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken when valid |
| cmd_op_i | input | 2 | 0 address load, 1 write, 2 read, 3 reserved |
| cmd_data_i | input | 16 | Address or write data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout or reserved code, valid with done_o |
| rdata_o | output | 16 | Word captured by the last read |
| cr_din_o | output | 16 | Data bus toward the PHY |
| cr_cap_addr_o | output | 1 | Capture-address strobe |
| cr_cap_data_o | output | 1 | Capture-data strobe |
| cr_write_o | output | 1 | Write-commit strobe |
| cr_read_o | output | 1 | Read strobe |
| cr_ack_i | input | 1 | PHY acknowledge |
| cr_dout_i | input | 16 | PHY return data |

## Verification
The hardest cases to reach are the ones where the PHY misbehaves: an acknowledge that never rises, an acknowledge that sticks high after the strobe drops, and a PHY that goes silent once it receives the reset bit. The bench's PHY model has a switch for each of these faults. A stuck-high fault is triggered through a read, which shows that the error path clears the strobes and that the next command still completes. The model also has a selectable acknowledge delay, which moves the handshake edges to different cycles. A memory inside the model checks written values by reading them back.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } cr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RISE = 2'd1,
    ST_FALL = 2'd2,
    ST_DONE = 2'd3
  } cr_state_e;

  localparam int unsigned NSTRB = 4;
  localparam logic [1:0] SB_CAPA = 2'd0;
  localparam logic [1:0] SB_CAPD = 2'd1;
  localparam logic [1:0] SB_WR   = 2'd2;
  localparam logic [1:0] SB_RD   = 2'd3;
  localparam int unsigned RST_BIT = 0;

  function automatic logic [NSTRB-1:0] strb_oh(input logic [1:0] idx);
    strb_oh = NSTRB'(1) << idx;
  endfunction
endpackage

// File: rtl/cr_wait_timer.sv
module cr_wait_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/cr_strobe_bank.sv
module cr_strobe_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] val_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[i] <= 1'b0;
      else if (load_i) q_o[i] <= val_i[i];
    end
  end
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import cr_pkg::*;
#(
  parameter int unsigned LIMIT = 100,
  parameter int unsigned DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [1:0]    cmd_op_i,
  input  logic [DW-1:0] cmd_data_i,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] cr_din_o,
  output logic          cr_cap_addr_o,
  output logic          cr_cap_data_o,
  output logic          cr_write_o,
  output logic          cr_read_o,
  input  logic          cr_ack_i,
  input  logic [DW-1:0] cr_dout_i
);
  cr_state_e         state_q, state_d;
  logic [1:0]        step_q, step_d;
  logic              err_q, err_d;
  logic [DW-1:0]     din_q, rdata_q;
  logic              accept, din_ld, cap_rd;
  logic              strb_ld;
  logic [NSTRB-1:0]  strb_nx, strb_q;
  logic              tmr_clr, tmr_run, tmr_exp;

  cr_wait_timer #(.LIMIT(LIMIT)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .run_i     (tmr_run),
    .expired_o (tmr_exp)
  );

  cr_strobe_bank #(.N(NSTRB)) u_strb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (strb_ld),
    .val_i  (strb_nx),
    .q_o    (strb_q)
  );

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    err_d   = err_q;
    accept  = 1'b0;
    din_ld  = 1'b0;
    cap_rd  = 1'b0;
    strb_ld = 1'b0;
    strb_nx = '0;
    tmr_clr = 1'b0;
    tmr_run = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          accept  = 1'b1;
          err_d   = 1'b0;
          tmr_clr = 1'b1;
          unique case (cr_op_e'(cmd_op_i))
            OP_ADDR:  begin step_d = SB_CAPA; din_ld = 1'b1; end
            OP_WRITE: begin step_d = SB_CAPD; din_ld = 1'b1; end
            OP_READ:  step_d = SB_RD;
            default:  err_d = 1'b1;
          endcase
          if (cr_op_e'(cmd_op_i) == OP_RSVD) begin
            state_d = ST_DONE;
          end else begin
            strb_ld = 1'b1;
            strb_nx = strb_oh(step_d);
            state_d = ST_RISE;
          end
        end
      end
      ST_RISE: begin
        tmr_run = 1'b1;
        if (cr_ack_i) begin
          cap_rd  = (step_q == SB_RD);
          strb_ld = 1'b1;
          tmr_clr = 1'b1;
          state_d = ST_FALL;
        end else if (tmr_exp) begin
          strb_ld = 1'b1;
          err_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_FALL: begin
        tmr_run = 1'b1;
        if (!cr_ack_i) begin
          tmr_clr = 1'b1;
          if (step_q == SB_CAPD) begin
            // commit strobe; PHY reset bit means no answer will come
            step_d  = SB_WR;
            strb_ld = 1'b1;
            strb_nx = strb_oh(SB_WR);
            state_d = din_q[RST_BIT] ? ST_DONE : ST_RISE;
          end else begin
            state_d = ST_DONE;
          end
        end else if (tmr_exp) begin
          err_d   = 1'b1;
          state_d = ST_DONE;
        end
      end
      default: begin
        strb_ld = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= SB_CAPA;
      err_q   <= 1'b0;
      din_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      err_q   <= err_d;
      if (accept && din_ld) din_q   <= cmd_data_i;
      if (cap_rd)           rdata_q <= cr_dout_i;
    end
  end

  assign cmd_ready_o   = (state_q == ST_IDLE);
  assign done_o        = (state_q == ST_DONE);
  assign err_o         = done_o && err_q;
  assign rdata_o       = rdata_q;
  assign cr_din_o      = din_q;
  assign cr_cap_addr_o = strb_q[SB_CAPA];
  assign cr_cap_data_o = strb_q[SB_CAPD];
  assign cr_write_o    = strb_q[SB_WR];
  assign cr_read_o     = strb_q[SB_RD];
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_ready_o,
  input logic          done_o,
  input logic          err_o,
  input logic [DW-1:0] cr_din_o,
  input logic          cr_cap_addr_o,
  input logic          cr_cap_data_o,
  input logic          cr_write_o,
  input logic          cr_read_o
);
  logic [3:0] strb;
  assign strb = {cr_read_o, cr_write_o, cr_cap_data_o, cr_cap_addr_o};

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strb)); // R9
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (strb == 4'b0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_ERR_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (strb == 4'b0)); // R8
  AST_DIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|strb) && $past(|strb)) |-> $stable(cr_din_o)); // R11
  AST_FIRE_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cr_write_o) && done_o) |-> (cr_din_o[0] && !err_o)); // R5
endmodule

bind phy_cr_master phy_cr_master_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_phy_cr_master.sv
module sim_phy_cr_master;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_data = 16'd0;
  logic        cmd_ready, done, err;
  logic [15:0] rdata, din, dout;
  logic        s_ca, s_cd, s_wr, s_rd, ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_cr_master #(.LIMIT(TMO), .DW(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_data_i(cmd_data),
    .done_o(done), .err_o(err), .rdata_o(rdata),
    .cr_din_o(din), .cr_cap_addr_o(s_ca), .cr_cap_data_o(s_cd),
    .cr_write_o(s_wr), .cr_read_o(s_rd),
    .cr_ack_i(ack), .cr_dout_i(dout)
  );

  // PHY model
  logic [15:0] mem [16];
  logic [15:0] p_addr, p_stage;
  logic [3:0]  sh;
  logic        stick, pca, pcd, pwr;
  logic [1:0]  dly = 2'd0;
  bit          blk = 0, stick_en = 0;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
  end

  always_comb ack = sh[dly] | stick;
  assign dout = mem[p_addr[3:0]];

  always @(posedge clk) begin
    logic tgt;
    tgt = (s_ca | s_cd | s_wr | s_rd) && !blk && !(s_wr && p_stage[0]);
    sh <= {sh[2:0], tgt};
    if (!stick_en) stick <= 1'b0;
    else if (ack)  stick <= 1'b1;
    pca <= s_ca; pcd <= s_cd; pwr <= s_wr;
    if (s_ca && !pca) p_addr <= din;
    if (s_cd && !pcd) p_stage <= din;
    if (s_wr && !pwr) mem[p_addr[3:0]] <= p_stage;
  end

  initial begin
    sh = '0; stick = 1'b0; pca = 0; pcd = 0; pwr = 0;
    p_addr = '0; p_stage = '0;
  end

  // scoreboard
  typedef struct packed { logic e; logic chk; logic [15:0] rd; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, hi_cnt = 0;
  logic last_wr = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (s_ca | s_cd | s_wr | s_rd) hi_cnt++;
      if (done) begin
        last_wr = s_wr;
        if (exp_q.size() == 0) begin
          check("R2 unexpected done", 1, 0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check("R6 R7 R10 err flag", 32'(err), 32'(x.e));
          if (x.chk) check("R4 read data", 32'(rdata), 32'(x.rd));
        end
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic [15:0] d,
                      input logic e, input logic chk, input logic [15:0] rd);
    exp_q.push_back('{e: e, chk: chk, rd: rd});
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    hi_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R9 ready low after accept", 32'(cmd_ready), 0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", 32'(cmd_ready), 1);
    check("R1 strobes in reset", 32'({s_ca, s_cd, s_wr, s_rd}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", 32'(done), 0);
    check("R1 din after reset", 32'(din), 0);

    send(2'd0, 16'h0003, 0, 0, 0);                 // R2
    check("R2 address on bus", 32'(din), 32'h3);
    send(2'd1, 16'h5A5A, 0, 0, 0);                 // R3
    send(2'd2, 16'hFFFF, 0, 1, 16'h5A5A);          // R4
    check("R11 read keeps din", 32'(din), 32'h5A5A);

    dly = 2'd2;
    send(2'd0, 16'h0009, 0, 0, 0);
    send(2'd1, 16'h1234, 0, 0, 0);                 // R3
    send(2'd2, 16'h0000, 0, 1, 16'h1234);          // R4
    send(2'd0, 16'h0003, 0, 0, 0);
    send(2'd2, 16'h0000, 0, 1, 16'h5A5A);          // R3 commit kept apart

    dly = 2'd0;
    send(2'd1, 16'h00F1, 0, 0, 0);                 // R5
    check("R5 write high with done", 32'(last_wr), 1);
    check("R5 write dropped after", 32'(s_wr), 0);

    blk = 1;
    send(2'd0, 16'h0005, 1, 0, 0);                 // R6
    check("R6 strobe high cycles", 32'(hi_cnt), TMO);
    check("R8 strobes low after error", 32'({s_ca, s_cd, s_wr, s_rd}), 0);
    blk = 0;

    stick_en = 1;
    send(2'd2, 16'h0000, 1, 0, 0);                 // R7
    stick_en = 0;
    repeat (3) @(negedge clk);

    send(2'd0, 16'h0009, 0, 0, 0);                 // R8 recovery
    send(2'd2, 16'h0000, 0, 1, 16'h1234);

    send(2'd3, 16'hAAAA, 1, 0, 0);                 // R10
    check("R10 no strobe", 32'(hi_cnt), 0);
    check("R11 reserved keeps din", 32'(din), 32'h0009);

    summary();
    $finish;
  end
endmodule